// File: doc/BRIEF.md
# Configurable Parallel Bus Master

This block runs single read and write cycles on an external parallel bus with 8-bit or 16-bit devices. Examples are display controllers, static memories and companion controllers. The host side holds three pieces of state. A current-address register (24 bits) carries two chip-select flags next to it. A single data holding register keeps the write data of the last write command and the read data of the last read. A bank of plain configuration pins selects the bus style. Those pins set the data width, the strobe style, address multiplexing, the per-signal polarity, the three wait-state phases and the address step direction.

Commands enter on a valid/ready channel. `cmd_ready` is high only while the block is enabled and idle. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. While a bus cycle is in flight, `cmd_ready` stays low and the host must hold its command until the cycle completes. The host loads the address and chip-select flags with `addr_load`. After each completed cycle the address can step up or down on its own, so the host can stream through consecutive locations.

Each cycle runs through these phases in order:
- two one-cycle address latch phases, used only when multiplexing is on;
- a setup phase of `setup_cyc` cycles;
- a strobe phase of `strobe_cyc`+1 cycles;
- a hold phase of `hold_cyc` cycles.

Top module: `pbus_master`

## Requirements
- R1: While `rst_n` is low, and after it rises, the state is as follows. `busy` is 0 and `bus_doe` is 0. Every control output sits at its inactive level. `rdata` and `bus_addr` are 0. `cmd_ready` equals `en`.
- R2: An accepted command holds `busy` high for exactly 2*`mux_en` + `setup_cyc` + (`strobe_cyc`+1) + `hold_cyc` cycles. During that time `cmd_ready` is 0, and any command offered is not taken.
- R3: The strobe style depends on `style_en`.
  - With `style_en`=0, `strb_a` is the read strobe and `strb_b` is the write strobe. Only the strobe that matches the command direction is active, for `strobe_cyc`+1 cycles.
  - With `style_en`=1, `strb_b` is an enable strobe, active for `strobe_cyc`+1 cycles. `strb_a` is a direction line: 1 for read and 0 for write while busy, and 1 when idle.
- R4: `pol` sets the active level of each control output, where 1 means active high. Bit 0 controls `bus_cs[0]`, bit 1 controls `bus_cs[1]`, bit 2 controls the read strobe, bit 3 controls `strb_b`, and bit 4 controls both `ale_lo` and `ale_hi`. An inactive output sits at the opposite level.
- R5: When `mux_en`=1, the cycle starts with two single latch cycles. In the first, `ale_lo` is active and `bus_dout` = {8'h00, addr[7:0]}. In the second, `ale_hi` is active and `bus_dout` = {8'h00, addr[15:8]}. `bus_doe` is 1 in both. The latch strobes are never active outside these cycles.
- R6: In a write cycle, from setup through hold, `bus_doe` is 1 and `bus_dout` carries the holding register. With `wide`=0, only its low byte is driven and the upper byte is 0.
- R7: In a read cycle, `bus_doe` is 0 outside the latch cycles. `bus_din` is sampled on the last strobe cycle into the holding register, which `rdata` shows. With `wide`=0, the upper byte is stored as 0.
- R8: When a cycle completes, the address follows `step_mode`: 0 keeps it, 1 adds one, 2 subtracts one, and 3 keeps it. The step wraps modulo 2^24.
- R9: `bus_cs[k]` is active during every busy cycle when stored chip-select flag k is 1, and inactive otherwise. `bus_addr` shows the current address at all times.
- R10: Lowering `en` aborts a cycle in progress by the next clock edge, which clears `busy` and deactivates all controls. It leaves the address and the holding register unchanged. No command is accepted while `en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Module enable; low aborts activity |
| wide | input | 1 | 1 = 16-bit data path, 0 = 8-bit |
| mux_en | input | 1 | Address multiplexed on data lines |
| style_en | input | 1 | 0 = read/write strobes, 1 = direction line + enable |
| pol | input | 5 | Active level per control output |
| setup_cyc | input | 4 | Setup phase length in cycles |
| strobe_cyc | input | 4 | Strobe phase length minus one |
| hold_cyc | input | 4 | Hold phase length in cycles |
| step_mode | input | 2 | Address step after each cycle |
| addr_load | input | 1 | Load address and chip-select flags |
| addr_in | input | 24 | Address to load |
| cs_in | input | 2 | Chip-select flags to load |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_wdata | input | 16 | Write data for the holding register |
| rdata | output | 16 | Holding register contents |
| busy | output | 1 | Bus cycle in progress |
| bus_addr | output | 24 | Address bus |
| bus_dout | output | 16 | Data bus outgoing value |
| bus_doe | output | 1 | Data bus output enable |
| bus_din | input | 16 | Data bus incoming value |
| bus_cs | output | 2 | Chip selects |
| strb_a | output | 1 | Read strobe or direction line |
| strb_b | output | 1 | Write strobe or enable strobe |
| ale_lo | output | 1 | Low address latch strobe |
| ale_hi | output | 1 | High address latch strobe |

## Verification
Several properties are checked on every cycle. The assertions cover the abort on disable, and that the high latch phase always follows the low one. They also cover that the read and write strobes are never active together in the split-strobe style and that the data bus is driven only while busy. Finally, they check that the address moves only on a completed cycle, and by one when stepping up. Other behaviour shows only in the bench's scenarios, which count cycles per phase under each timing and style combination. This covers the exact busy length, the strobe widths, the byte values on the latch cycles and the masking of read and write data in 8-bit mode. It also covers the wrap of the address at both ends of its range, and that the address and holding register are untouched after a mid-cycle abort.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ALO   = 3'd1,
    ST_AHI   = 3'd2,
    ST_SETUP = 3'd3,
    ST_STRB  = 3'd4,
    ST_HOLD  = 3'd5
  } phase_e;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_INC  = 2'd1,
    STEP_DEC  = 2'd2,
    STEP_KEEP = 2'd3
  } step_e;

  localparam int POL_W  = 5;
  localparam int BYTE_W = 8;
  localparam int CS_N   = 2;

endpackage

// File: rtl/pbus_seq.sv
module pbus_seq
  import pbus_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             start,
  input  logic             is_write,
  input  logic             mux_en,
  input  logic [CNT_W-1:0] setup_len,
  input  logic [CNT_W-1:0] strobe_len,
  input  logic [CNT_W-1:0] hold_len,
  output phase_e           phase,
  output logic             dir_wr,
  output logic             last_strobe,
  output logic             done
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt;
  phase_e           first_ph;
  phase_e           next_ph;
  logic             at_end;

  function automatic logic [CNT_W-1:0] span_of(
    input phase_e           p,
    input logic [CNT_W-1:0] su,
    input logic [CNT_W-1:0] wd,
    input logic [CNT_W-1:0] hd
  );
    case (p)
      ST_SETUP: return su - ONE;
      ST_STRB:  return wd;
      ST_HOLD:  return hd - ONE;
      default:  return '0;
    endcase
  endfunction

  always_comb begin
    if (mux_en)               first_ph = ST_ALO;
    else if (setup_len != '0) first_ph = ST_SETUP;
    else                      first_ph = ST_STRB;
  end

  always_comb begin
    case (phase)
      ST_ALO:   next_ph = ST_AHI;
      ST_AHI:   next_ph = (setup_len != '0) ? ST_SETUP : ST_STRB;
      ST_SETUP: next_ph = ST_STRB;
      ST_STRB:  next_ph = (hold_len != '0) ? ST_HOLD : ST_IDLE;
      default:  next_ph = ST_IDLE;
    endcase
  end

  assign at_end      = (phase != ST_IDLE) && (cnt == '0);
  assign done        = en && at_end && (next_ph == ST_IDLE);
  assign last_strobe = en && (phase == ST_STRB) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= ST_IDLE;
      cnt    <= '0;
      dir_wr <= 1'b0;
    end else if (!en) begin
      phase  <= ST_IDLE;
      cnt    <= '0;
    end else if (phase == ST_IDLE) begin
      if (start) begin
        phase  <= first_ph;
        cnt    <= span_of(first_ph, setup_len, strobe_len, hold_len);
        dir_wr <= is_write;
      end
    end else if (cnt != '0) begin
      cnt <= cnt - ONE;
    end else begin
      phase <= next_ph;
      cnt   <= span_of(next_ph, setup_len, strobe_len, hold_len);
    end
  end

  // R10
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (phase == ST_IDLE));

  // R5
  ale_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == ST_ALO && en) |=> (phase == ST_AHI));

endmodule

// File: rtl/pbus_addr_reg.sv
module pbus_addr_reg
  import pbus_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [CS_N-1:0]   cs_in,
  input  logic              done,
  input  step_e             step_mode,
  output logic [ADDR_W-1:0] addr_q,
  output logic [CS_N-1:0]   cs_q
);

  localparam logic [ADDR_W-1:0] A_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      cs_q   <= '0;
    end else if (load) begin
      addr_q <= addr_in;
      cs_q   <= cs_in;
    end else if (done) begin
      case (step_mode)
        STEP_INC: addr_q <= addr_q + A_ONE;
        STEP_DEC: addr_q <= addr_q - A_ONE;
        default:  addr_q <= addr_q;
      endcase
    end
  end

  // R8
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load && step_mode == STEP_INC) |=> (addr_q == $past(addr_q) + A_ONE));

  // R8
  addr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !load) |=> $stable(addr_q));

endmodule

// File: rtl/pbus_pins.sv
module pbus_pins
  import pbus_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  phase_e            phase,
  input  logic              dir_wr,
  input  logic              style_en,
  input  logic              wide,
  input  logic [POL_W-1:0]  pol,
  input  logic [CS_N-1:0]   cs_q,
  input  logic [15:0]       addr_lo,
  input  logic [DATA_W-1:0] hold_q,
  output logic [CS_N-1:0]   bus_cs,
  output logic              strb_a,
  output logic              strb_b,
  output logic              ale_lo,
  output logic              ale_hi,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe
);

  localparam int NSIG = 6;
  localparam logic [DATA_W-BYTE_W-1:0] UPPER_Z = '0;

  logic            active;
  logic            strobe;
  logic            data_ph;
  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] lvl;

  assign active  = (phase != ST_IDLE);
  assign strobe  = (phase == ST_STRB);
  assign data_ph = (phase == ST_SETUP) || (phase == ST_STRB) || (phase == ST_HOLD);

  assign raw[0] = active & cs_q[0];
  assign raw[1] = active & cs_q[1];
  assign raw[2] = strobe & ~dir_wr & ~style_en;
  assign raw[3] = strobe & (style_en | dir_wr);
  assign raw[4] = (phase == ST_ALO);
  assign raw[5] = (phase == ST_AHI);

  for (genvar g = 0; g < NSIG; g++) begin : g_pol
    localparam int PI = (g > POL_W - 1) ? POL_W - 1 : g;
    assign lvl[g] = raw[g] ~^ pol[PI];
  end

  assign bus_cs = lvl[1:0];
  assign strb_a = style_en ? (active ? ~dir_wr : 1'b1) : lvl[2];
  assign strb_b = lvl[3];
  assign ale_lo = lvl[4];
  assign ale_hi = lvl[5];

  always_comb begin
    bus_dout = '0;
    bus_doe  = 1'b0;
    if (phase == ST_ALO) begin
      bus_dout = {UPPER_Z, addr_lo[BYTE_W-1:0]};
      bus_doe  = 1'b1;
    end else if (phase == ST_AHI) begin
      bus_dout = {UPPER_Z, addr_lo[2*BYTE_W-1:BYTE_W]};
      bus_doe  = 1'b1;
    end else if (data_ph && dir_wr) begin
      bus_dout = wide ? hold_q : {UPPER_Z, hold_q[BYTE_W-1:0]};
      bus_doe  = 1'b1;
    end
  end

endmodule

// File: rtl/pbus_master.sv
module pbus_master
  import pbus_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wide,
  input  logic              mux_en,
  input  logic              style_en,
  input  logic [4:0]        pol,
  input  logic [CNT_W-1:0]  setup_cyc,
  input  logic [CNT_W-1:0]  strobe_cyc,
  input  logic [CNT_W-1:0]  hold_cyc,
  input  logic [1:0]        step_mode,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [1:0]        cs_in,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              busy,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  input  logic [DATA_W-1:0] bus_din,
  output logic [1:0]        bus_cs,
  output logic              strb_a,
  output logic              strb_b,
  output logic              ale_lo,
  output logic              ale_hi
);

  localparam logic [DATA_W-BYTE_W-1:0] UPPER_Z = '0;

  phase_e            phase;
  logic              dir_wr;
  logic              last_strobe;
  logic              done;
  logic              accept;
  logic [DATA_W-1:0] hold_q;
  logic [CS_N-1:0]   cs_q;
  logic [ADDR_W-1:0] addr_q;

  assign busy      = (phase != ST_IDLE);
  assign cmd_ready = en && !busy;
  assign accept    = cmd_valid && cmd_ready;
  assign rdata     = hold_q;
  assign bus_addr  = addr_q;

  pbus_seq #(.CNT_W(CNT_W)) i_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .start       (accept),
    .is_write    (cmd_write),
    .mux_en      (mux_en),
    .setup_len   (setup_cyc),
    .strobe_len  (strobe_cyc),
    .hold_len    (hold_cyc),
    .phase       (phase),
    .dir_wr      (dir_wr),
    .last_strobe (last_strobe),
    .done        (done)
  );

  pbus_addr_reg #(.ADDR_W(ADDR_W)) i_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (addr_load),
    .addr_in   (addr_in),
    .cs_in     (cs_in),
    .done      (done),
    .step_mode (step_e'(step_mode)),
    .addr_q    (addr_q),
    .cs_q      (cs_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (accept && cmd_write) begin
      hold_q <= cmd_wdata;
    end else if (last_strobe && !dir_wr) begin
      hold_q <= wide ? bus_din : {UPPER_Z, bus_din[BYTE_W-1:0]};
    end
  end

  pbus_pins #(.DATA_W(DATA_W)) i_pins (
    .phase    (phase),
    .dir_wr   (dir_wr),
    .style_en (style_en),
    .wide     (wide),
    .pol      (pol),
    .cs_q     (cs_q),
    .addr_lo  (addr_q[15:0]),
    .hold_q   (hold_q),
    .bus_cs   (bus_cs),
    .strb_a   (strb_a),
    .strb_b   (strb_b),
    .ale_lo   (ale_lo),
    .ale_hi   (ale_hi),
    .bus_dout (bus_dout),
    .bus_doe  (bus_doe)
  );

  // R3
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !style_en |-> !((strb_a == pol[2]) && (strb_b == pol[3])));

  // R6
  doe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> busy);

  // R10
  no_accept_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy);

endmodule

// File: tb/test_pbus_master.sv
module test_pbus_master;

  typedef struct packed {
    logic        wr;
    logic        wide;
    logic        mux;
    logic        sty;
    logic [4:0]  pol;
    logic [3:0]  su;
    logic [3:0]  wd;
    logic [3:0]  hd;
    logic [1:0]  step;
    logic [1:0]  cs;
    logic [23:0] addr;
    logic [15:0] wdat;
    logic [7:0]  exp_busy;
    logic [23:0] exp_addr;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 1'b1, 1'b0, 1'b0, 5'b00000, 4'd1,  4'd2,  4'd1,  2'd1, 2'b01, 24'h000010, 16'h0000, 8'd5,  24'h000011},
    '{1'b1, 1'b1, 1'b0, 1'b0, 5'b00000, 4'd0,  4'd0,  4'd0,  2'd2, 2'b10, 24'h000010, 16'hBEEF, 8'd1,  24'h00000F},
    '{1'b0, 1'b0, 1'b1, 1'b1, 5'b11111, 4'd2,  4'd1,  4'd0,  2'd0, 2'b11, 24'h123456, 16'h0000, 8'd6,  24'h123456},
    '{1'b1, 1'b1, 1'b1, 1'b1, 5'b01010, 4'd0,  4'd3,  4'd2,  2'd1, 2'b01, 24'h00FFFF, 16'h1234, 8'd8,  24'h010000},
    '{1'b0, 1'b1, 1'b0, 1'b1, 5'b10101, 4'd15, 4'd15, 4'd15, 2'd2, 2'b10, 24'h000000, 16'h0000, 8'd46, 24'hFFFFFF},
    '{1'b1, 1'b0, 1'b0, 1'b0, 5'b11111, 4'd3,  4'd0,  4'd4,  2'd3, 2'b00, 24'hABCDEF, 16'hA55A, 8'd8,  24'hABCDEF},
    '{1'b0, 1'b1, 1'b1, 1'b0, 5'b00000, 4'd0,  4'd0,  4'd0,  2'd1, 2'b11, 24'hFFFFFF, 16'h0000, 8'd3,  24'h000000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b1;
  logic        wide = 1'b1, mux_en = 1'b0, style_en = 1'b0;
  logic [4:0]  pol = '0;
  logic [3:0]  setup_cyc = '0, strobe_cyc = '0, hold_cyc = '0;
  logic [1:0]  step_mode = '0;
  logic        addr_load = 1'b0;
  logic [23:0] addr_in = '0;
  logic [1:0]  cs_in = '0;
  logic        cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [15:0] cmd_wdata = '0;
  logic        cmd_ready, busy, bus_doe, strb_a, strb_b, ale_lo, ale_hi;
  logic [15:0] rdata, bus_dout, bus_din;
  logic [23:0] bus_addr;
  logic [1:0]  bus_cs;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  function automatic logic [15:0] dev_model(input logic [23:0] a);
    return {a[7:0] ^ 8'h3C, a[15:8] ^ a[23:16] ^ 8'hC3};
  endfunction

  assign bus_din = dev_model(bus_addr);

  pbus_master i_pbus_master (
    .clk(clk), .rst_n(rst_n), .en(en), .wide(wide), .mux_en(mux_en),
    .style_en(style_en), .pol(pol), .setup_cyc(setup_cyc),
    .strobe_cyc(strobe_cyc), .hold_cyc(hold_cyc), .step_mode(step_mode),
    .addr_load(addr_load), .addr_in(addr_in), .cs_in(cs_in),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_wdata(cmd_wdata), .rdata(rdata), .busy(busy), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din),
    .bus_cs(bus_cs), .strb_a(strb_a), .strb_b(strb_b),
    .ale_lo(ale_lo), .ale_hi(ale_hi)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    int nb = 0, ns = 0, na = 0, ecs = 0, edir = 0, edat = 0, erdy = 0;
    logic [15:0] expw;
    logic [15:0] expr;
    expw = v.wide ? v.wdat : {8'h00, v.wdat[7:0]};
    expr = v.wide ? dev_model(v.addr) : {8'h00, dev_model(v.addr)[7:0]};
    @(negedge clk);
    wide = v.wide; mux_en = v.mux; style_en = v.sty; pol = v.pol;
    setup_cyc = v.su; strobe_cyc = v.wd; hold_cyc = v.hd; step_mode = v.step;
    addr_load = 1'b1; addr_in = v.addr; cs_in = v.cs;
    cmd_write = v.wr; cmd_wdata = v.wdat;
    @(negedge clk);
    addr_load = 1'b0;
    // R4 idle levels are the inverse of pol
    check("R4", "idle control levels", {bus_cs, strb_b, ale_lo, ale_hi},
          {~v.pol[1:0], ~v.pol[3], ~v.pol[4], ~v.pol[4]});
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (busy && nb < 200) begin
      nb++;
      if (bus_cs != (v.cs ~^ v.pol[1:0])) ecs++;
      if (ale_lo == v.pol[4] || ale_hi == v.pol[4]) begin
        na++;
        if (!bus_doe) edat++;
        if (ale_lo == v.pol[4] && bus_dout != {8'h00, v.addr[7:0]}) edat++;
        if (ale_hi == v.pol[4] && bus_dout != {8'h00, v.addr[15:8]}) edat++;
      end else if (v.wr) begin
        if (!bus_doe || bus_dout != expw) edat++;
      end else if (bus_doe) begin
        edat++;
      end
      if (v.sty) begin
        if (strb_b == v.pol[3]) ns++;
        if (strb_a != !v.wr) edir++;
      end else begin
        if (v.wr ? (strb_a == v.pol[2]) : (strb_b == v.pol[3])) edir++;
        if (v.wr ? (strb_b == v.pol[3]) : (strb_a == v.pol[2])) ns++;
      end
      if (cmd_ready) erdy++;
      @(negedge clk);
    end
    check("R2", "busy cycles", nb, v.exp_busy);
    check("R2", "ready while busy", erdy, 0);
    check("R3", "strobe cycles", ns, v.wd + 1);
    check("R3", "wrong strobe or direction", edir, 0);
    check("R5", "latch cycles", na, v.mux ? 2 : 0);
    check("R6", "data bus errors", edat, 0);
    check("R9", "chip select errors", ecs, 0);
    check("R8", "address after cycle", bus_addr, v.exp_addr);
    if (!v.wr) check("R7", "read data", rdata, expr);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R2 watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] prev;
    repeat (3) @(negedge clk);
    // R1 reset state, pol all active low
    check("R1", "busy in reset", busy, 0);
    check("R1", "doe in reset", bus_doe, 0);
    check("R1", "controls in reset", {bus_cs, strb_a, strb_b, ale_lo, ale_hi}, 6'b111111);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "ready after reset", cmd_ready, 1);
    check("R1", "rdata after reset", rdata, 0);
    check("R1", "address after reset", bus_addr, 0);

    for (int i = 0; i < NVEC; i++) run_vec(VEC[i]);

    // R10 abort in the middle of a long read
    prev = rdata;
    @(negedge clk);
    wide = 1'b1; mux_en = 1'b0; style_en = 1'b0; pol = 5'b00000;
    setup_cyc = 4'd15; strobe_cyc = 4'd15; hold_cyc = 4'd15; step_mode = 2'd1;
    addr_load = 1'b1; addr_in = 24'h000100; cs_in = 2'b01; cmd_write = 1'b0;
    @(negedge clk);
    addr_load = 1'b0;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (20) @(negedge clk);
    check("R10", "busy before abort", busy, 1);
    en = 1'b0;
    cmd_valid = 1'b1;
    @(negedge clk);
    check("R10", "busy after abort", busy, 0);
    check("R10", "ready while disabled", cmd_ready, 0);
    check("R10", "rdata kept", rdata, prev);
    check("R10", "address kept", bus_addr, 24'h000100);
    check("R10", "controls inactive", {bus_cs, strb_a, strb_b}, 4'b1111);
    repeat (3) @(negedge clk);
    check("R10", "command ignored while disabled", busy, 0);
    cmd_valid = 1'b0;
    en = 1'b1;
    @(negedge clk);
    check("R10", "ready after enable", cmd_ready, 1);
    run_vec('{1'b0, 1'b1, 1'b0, 1'b0, 5'b00000, 4'd0, 4'd0, 4'd0, 2'd1, 2'b01,
              24'h000100, 16'h0000, 8'd1, 24'h000101});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule